// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps a horizontally microcoded controller for a small accumulator CPU. It keeps a 9-bit microinstruction address and drives the read address of an external 512 x 64-bit control store with a synchronous read. Each 64-bit microinstruction holds three things: a 6-bit page field, a 3-bit offset field and a 5-bit condition select. The rest of the word is control bits for the datapath. The next address takes its page from the page field. Its offset is the offset field with the least significant bit replaced by one status input, picked by the condition select.

The store's read port is driven with the next address. The word that comes back one clock later therefore always belongs to the address the block currently holds. A second register captures that word as the control output, so datapath controls change only on a clock edge and never glitch. The status inputs can be chosen from the eight opcode bits, the four ALU flags, the interrupt-enable flag, the loop-counter-zero signal, the memory wait line and the interrupt request. Two further codes give a constant 0 or 1 for unconditional moves. Multiway opcode dispatch is built by chaining bit tests over several microsteps. Selecting the wait line on an odd address makes a microinstruction repeat until memory releases the bus.

Top module: `useq_sequencer`

## Requirements
- R1: rst_ni low asynchronously clears uaddr_o and ctrl_o to 0. In the first clock after release, uaddr_o stays at 0 and rom_addr_o is held at 0 while the store output is primed. From the next clock on, sequencing starts from the word at address 0.
- R2: After each clock, bits 8..3 of uaddr_o equal the page field, bits 63..58 of the microinstruction that was current before that clock.
- R3: Bits 2..1 of the new address equal bits 2..1 of the offset field (word bits 57..55). Bit 0 is always the selected condition, whatever value offset bit 0 has.
- R4: Select codes 0 to 7 (word bits 54..50) choose ir_i bit 0 to bit 7 as the condition.
- R5: Select codes 8 to 15 choose, in this order: ovf_i, sign_i, zero_i, carry_i, int_en_i, loop_zero_i, mem_wait_i, irq_i.
- R6: Select code 30 yields a condition of 0 and code 31 yields 1. Codes 16 to 29 yield 0.
- R7: A word at an odd address that names its own page, has offset bits 2..1 matching that address, and selects mem_wait_i keeps uaddr_o on that address for as long as mem_wait_i is high. It moves to the even neighbour in the clock after mem_wait_i falls.
- R8: ctrl_o is registered. After each clock it holds the microinstruction that was current before that clock. During the priming cycle it stays 0.
- R9: rom_addr_o presents the address that uaddr_o will take at the coming clock. rom_data_i is expected one clock after rom_addr_o, from a store with a synchronous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 8 | Instruction register bits |
| ovf_i | input | 1 | Overflow flag |
| sign_i | input | 1 | Sign flag |
| zero_i | input | 1 | Zero flag |
| carry_i | input | 1 | Carry flag |
| int_en_i | input | 1 | Interrupt-enable flag |
| loop_zero_i | input | 1 | Loop counter equals zero |
| mem_wait_i | input | 1 | Memory not ready |
| irq_i | input | 1 | Interrupt request |
| rom_data_i | input | 64 | Control store read data (word at uaddr_o) |
| rom_addr_o | output | 9 | Control store read address (next address) |
| uaddr_o | output | 9 | Current microinstruction address |
| ctrl_o | output | 64 | Registered control word |

## Verification
rom_addr_o is combinational and is valid as soon as the status inputs settle, in the same cycle. uaddr_o follows one edge later, and ctrl_o shows the word one edge after the address that fetched it. The bench's store tags each word with its own address in the low control bits. This lets it check, at one falling edge, that uaddr_o has the new target and that ctrl_o carries the tag of the address before it. Status inputs change only on falling edges while uaddr_o sits at 0, where the word ignores them. They are consumed at the second rising edge after that, and the result is sampled at the falling edge that follows.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W  = 9;
  localparam int WORD_W  = 64;
  localparam int LO_W    = 3;
  localparam int SEL_W   = 5;
  localparam int IR_W    = 8;
  localparam int STAT_W  = 8;
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int HI_LSB  = WORD_W - HI_W;
  localparam int LO_LSB  = HI_LSB - LO_W;
  localparam int SEL_LSB = LO_LSB - SEL_W;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int SEL_W  = useq_pkg::SEL_W,
  parameter int IR_W   = useq_pkg::IR_W,
  parameter int STAT_W = useq_pkg::STAT_W
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              cond_o
);
  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] src;

  // opcode bits, then status, then zeros; top code is constant one
  always_comb begin
    src                         = '0;
    src[IR_W-1:0]               = ir_i;
    src[IR_W+STAT_W-1:IR_W]     = stat_i;
    src[NSRC-1]                 = 1'b1;
  end

  assign cond_o = src[sel_i];
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int ADDR_W = useq_pkg::ADDR_W,
  parameter int WORD_W = useq_pkg::WORD_W,
  parameter int LO_W   = useq_pkg::LO_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              cond_i,
  input  logic              run_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam int HI_W   = ADDR_W - LO_W;
  localparam int HI_LSB = WORD_W - HI_W;
  localparam int LO_LSB = HI_LSB - LO_W;

  logic [HI_W-1:0] page;
  logic [LO_W-1:0] ofs;

  assign page = word_i[WORD_W-1:HI_LSB];
  assign ofs  = word_i[HI_LSB-1:LO_LSB];

  // while priming, the store output is not yet valid: stay on entry point
  always_comb begin
    if (run_i) next_o = {page, ofs[LO_W-1:1], cond_i};
    else       next_o = '0;
  end
endmodule

// File: rtl/useq_addr_reg.sv
module useq_addr_reg #(
  parameter int ADDR_W = useq_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] next_i,
  output logic [ADDR_W-1:0] uaddr_o,
  output logic              run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uaddr_o <= '0;
      run_o   <= 1'b0;
    end else begin
      uaddr_o <= next_i;
      run_o   <= 1'b1;
    end
  end

  AST_PRIME_AT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> uaddr_o == '0); // R1
endmodule

// File: rtl/useq_ctrl_reg.sv
module useq_ctrl_reg #(
  parameter int WORD_W = useq_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_CTRL_QUIET_PRIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |-> q_o == '0); // R8
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int ADDR_W = useq_pkg::ADDR_W,
  parameter int WORD_W = useq_pkg::WORD_W,
  parameter int LO_W   = useq_pkg::LO_W,
  parameter int SEL_W  = useq_pkg::SEL_W,
  parameter int IR_W   = useq_pkg::IR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              ovf_i,
  input  logic              sign_i,
  input  logic              zero_i,
  input  logic              carry_i,
  input  logic              int_en_i,
  input  logic              loop_zero_i,
  input  logic              mem_wait_i,
  input  logic              irq_i,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [ADDR_W-1:0] uaddr_o,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam int STAT_W  = 8;
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int HI_LSB  = WORD_W - HI_W;
  localparam int LO_LSB  = HI_LSB - LO_W;
  localparam int SEL_LSB = LO_LSB - SEL_W;
  localparam logic [SEL_W-1:0] SEL_ONE  = '1;
  localparam logic [SEL_W-1:0] SEL_ZERO = SEL_ONE - 1'b1;

  logic [STAT_W-1:0] stat;
  logic [SEL_W-1:0]  sel;
  logic              cond;
  logic              run;
  logic [ADDR_W-1:0] next_addr;

  // bit order fixes the select code of each status input
  assign stat = {irq_i, mem_wait_i, loop_zero_i, int_en_i,
                 carry_i, zero_i, sign_i, ovf_i};
  assign sel  = rom_data_i[LO_LSB-1:SEL_LSB];

  useq_cond_mux #(.SEL_W(SEL_W), .IR_W(IR_W), .STAT_W(STAT_W)) u_cond (
    .sel_i  (sel),
    .ir_i   (ir_i),
    .stat_i (stat),
    .cond_o (cond)
  );

  useq_next_addr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LO_W(LO_W)) u_next (
    .word_i (rom_data_i),
    .cond_i (cond),
    .run_i  (run),
    .next_o (next_addr)
  );

  useq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (next_addr),
    .uaddr_o (uaddr_o),
    .run_o   (run)
  );

  useq_ctrl_reg #(.WORD_W(WORD_W)) u_creg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (run),
    .d_i    (rom_data_i),
    .q_o    (ctrl_o)
  );

  assign rom_addr_o = next_addr;

  AST_PAGE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> uaddr_o[ADDR_W-1:LO_W] == $past(rom_data_i[WORD_W-1:HI_LSB])); // R2
  AST_OFFSET_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> uaddr_o[LO_W-1:1] == $past(rom_data_i[HI_LSB-1:LO_LSB+1])); // R3
  AST_IR_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && int'(sel) < IR_W) |=> uaddr_o[0] == $past(ir_i[sel[$clog2(IR_W)-1:0]])); // R4
  AST_FORCE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sel == SEL_ONE) |=> uaddr_o[0]); // R6
  AST_FORCE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sel == SEL_ZERO) |=> !uaddr_o[0]); // R6
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
  typedef struct packed {
    logic [5:0] hi;
    logic [2:0] lo;
    logic [4:0] sel;
    logic [7:0] ir;
    logic [7:0] flg;
    logic [8:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{6'd2,  3'd6, 5'd0,  8'h01, 8'h00, 9'd23,  4'd4},
    '{6'd2,  3'd6, 5'd0,  8'hFE, 8'hFF, 9'd22,  4'd4},
    '{6'd2,  3'd7, 5'd3,  8'h08, 8'h00, 9'd23,  4'd3},
    '{6'd2,  3'd7, 5'd3,  8'hF7, 8'hFF, 9'd22,  4'd3},
    '{6'd3,  3'd2, 5'd7,  8'h80, 8'h00, 9'd27,  4'd4},
    '{6'd3,  3'd2, 5'd7,  8'h7F, 8'hFF, 9'd26,  4'd4},
    '{6'd4,  3'd4, 5'd8,  8'h00, 8'h01, 9'd37,  4'd5},
    '{6'd4,  3'd4, 5'd9,  8'hFF, 8'hFD, 9'd36,  4'd5},
    '{6'd5,  3'd0, 5'd10, 8'h00, 8'h04, 9'd41,  4'd5},
    '{6'd5,  3'd0, 5'd11, 8'h00, 8'h08, 9'd41,  4'd5},
    '{6'd6,  3'd2, 5'd12, 8'h00, 8'h10, 9'd51,  4'd5},
    '{6'd6,  3'd2, 5'd13, 8'h00, 8'h20, 9'd51,  4'd5},
    '{6'd7,  3'd4, 5'd14, 8'h00, 8'h40, 9'd61,  4'd5},
    '{6'd7,  3'd4, 5'd15, 8'h00, 8'h80, 9'd61,  4'd5},
    '{6'd7,  3'd4, 5'd15, 8'hFF, 8'h7F, 9'd60,  4'd5},
    '{6'd63, 3'd7, 5'd20, 8'hFF, 8'hFF, 9'd510, 4'd6},
    '{6'd10, 3'd1, 5'd30, 8'hFF, 8'hFF, 9'd80,  4'd6},
    '{6'd10, 3'd0, 5'd31, 8'h00, 8'h00, 9'd81,  4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ir = '0;
  logic [7:0]  flg = '0;
  logic [5:0]  vec_hi = '0;
  logic [2:0]  vec_lo = '0;
  logic [4:0]  vec_sel = 5'd30;
  logic [63:0] rom_q = '0;
  logic [8:0]  rom_addr;
  logic [8:0]  uaddr;
  logic [63:0] ctrl;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ir_i        (ir),
    .ovf_i       (flg[0]),
    .sign_i      (flg[1]),
    .zero_i      (flg[2]),
    .carry_i     (flg[3]),
    .int_en_i    (flg[4]),
    .loop_zero_i (flg[5]),
    .mem_wait_i  (flg[6]),
    .irq_i       (flg[7]),
    .rom_data_i  (rom_q),
    .rom_addr_o  (rom_addr),
    .uaddr_o     (uaddr),
    .ctrl_o      (ctrl)
  );

  // low control bits tag each word with its own address
  function automatic logic [63:0] rom_word(input logic [8:0] a);
    case (a)
      9'd0:    return {6'd1, 3'd0, 5'd30, 41'd0, a};
      9'd8:    return {vec_hi, vec_lo, vec_sel, 41'd0, a};
      9'd9:    return {6'd1, 3'd0, 5'd14, 41'd0, a};
      default: return {6'd0, 3'd0, 5'd30, 41'd0, a};
    endcase
  endfunction

  always_ff @(posedge clk) rom_q <= rom_word(rom_addr);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "uaddr in reset", uaddr, 0);
    chk("R1", "ctrl in reset", ctrl, 0);
    chk("R1", "rom_addr in reset", rom_addr, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "uaddr priming", uaddr, 0);
    chk("R1", "ctrl priming", ctrl, 0);
    chk("R9", "rom_addr after prime", rom_addr, 8);

    // table walk: 0 -> 8 -> target -> 0
    for (int i = 0; i < NV; i++) begin
      vec_hi  = VECS[i].hi;
      vec_lo  = VECS[i].lo;
      vec_sel = VECS[i].sel;
      ir      = VECS[i].ir;
      flg     = VECS[i].flg;
      @(negedge clk);
      chk("R2", "uaddr at dispatch", uaddr, 8);
      chk("R8", "ctrl tag at dispatch", ctrl[8:0], 0);
      chk("R9", "rom_addr at dispatch", rom_addr, VECS[i].exp);
      @(negedge clk);
      chk(req_name(VECS[i].req), "branch target", uaddr, VECS[i].exp);
      chk("R8", "ctrl tag after branch", ctrl[8:0], 8);
      @(negedge clk);
      chk("R2", "return to entry", uaddr, 0);
      chk("R8", "ctrl tag of target", ctrl[8:0], VECS[i].exp);
    end

    // wait stall: 8 -> 9, hold on 9 while mem wait is high
    vec_hi = 6'd1; vec_lo = 3'd0; vec_sel = 5'd31;
    ir = '0; flg = 8'h40;
    @(negedge clk);
    chk("R7", "enter stall path", uaddr, 8);
    @(negedge clk);
    chk("R7", "stall entered", uaddr, 9);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7", "stall held", uaddr, 9);
      chk("R8", "ctrl tag during stall", ctrl[8:0], 9);
    end
    flg = 8'h00;
    vec_hi = 6'd2; vec_lo = 3'd6; vec_sel = 5'd31;
    @(negedge clk);
    chk("R7", "stall released", uaddr, 8);
    @(negedge clk);
    chk("R6", "forced one after stall", uaddr, 23);

    // asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1", "async clear uaddr", uaddr, 0);
    chk("R1", "async clear ctrl", ctrl, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "prime after reset", uaddr, 0);
    chk("R1", "ctrl quiet after reset", ctrl, 0);
    @(negedge clk);
    chk("R1", "restart from entry", uaddr, 8);
    chk("R8", "ctrl of entry word", ctrl[8:0], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule